// File: doc/BRIEF.md
# Serial Shift Master with Programmable Frame Length

This block is the master side of a four-wire synchronous serial link. It sits on a small byte-wide register bus. Software loads a byte into the shift register and picks a bit rate and a frame length. It then sets a run bit. The engine produces the serial clock and moves the frame out and in, most significant bit first. It clears the run bit itself when the frame is done.

The bit rate is the core clock divided by a fixed prescale factor, 13 by default. That result is divided again by a power of two, chosen by a 3-bit code. A frame carries from 1 to 15 bits, but the shift register holds only 8. Frames longer than 8 bits therefore keep only the last 8 bits received, which lets software discard unwanted leading bits of a stream. Two inputs set the clock polarity and the clock phase.

A sticky event flag can mark the end of each frame, and a mask turns that flag into an interrupt request. A separate enable bit hands the serial-out pin to the engine.

Top module: `spi_fm_master`

Register map. Address 0 is the data/shift register. Address 1 is the divider register: bit 7 is the event flag, bits 6:3 are the frame length and bits 2:0 are the rate code. Address 2 is the mode register: bit 0 is run, bit 1 is the flag enable and bit 2 is the interrupt mask. Address 3 is the write-only pin register: bit 0 is the output enable. The parameter PRESCALE must be at least 3.

## Requirements
- R1: After reset, the divider register and the mode register read 00h, `irq` and `sout_oe` are 0, and `sclk` equals `cpol`.
- R2: One bit lasts PRESCALE×ratio core cycles. Rate codes 0 to 7 give ratios 1, 2, 4, 8, 16, 32, 64 and 256. Take H = floor(bit period / 2). With `cpha`=0, `sclk` is in its active level (the inverse of `cpol`) for the last period−H cycles of each bit. With `cpha`=1, it is active for the first H cycles.
- R3: A frame carries exactly the number of bits in divider bits 6:3, for any value from 1 to 15. Setting run while that field is 0 leaves run at 0 and produces no clock edge.
- R4: Data moves most significant bit first. Bit k of a frame is driven on `sout` from bit 7 of the register as it stands at that point. The register shifts left and each received bit enters bit 0. After the frame, the register holds the last 8 bits of the sequence "initial byte, then the received bits".
- R5: `sin` is sampled on the mid-bit edge of `sclk`. With `cpha`=0 this is the change from idle to active level; with `cpha`=1 it is the change from active to idle. `sout` changes only at bit boundaries.
- R6: Writing 1 to mode bit 0 starts a frame. Hardware clears the bit after the last bit. Writing 0 to it while a frame runs has no effect.
- R7: While a frame runs, writes to addresses 0 and 1 are ignored.
- R8: The flag (divider bit 7) sets at the end of a frame when mode bit 1 is 1; it stays 0 when mode bit 1 is 0. Writing 0 to the flag clears it; writing 1 never sets it. `irq` equals flag AND mode bit 2, one cycle later.
- R9: Bit 0 written to address 3 drives `sout_oe`. Address 3 reads as 00h.
- R10: While no frame runs, `sclk` stays at the `cpol` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after `rd_addr` |
| cpol | input | 1 | Clock polarity, the idle level of `sclk` |
| cpha | input | 1 | Clock phase, which half-bit is active |
| sin | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Serial-out pin handed to the engine |
| irq | output | 1 | Masked end-of-frame interrupt request |

## Verification
The bench builds the block with PRESCALE=3. This keeps every bit period short, so the sweep can cover all eight rate codes, all four polarity/phase combinations and every frame length from 1 to 15 in a short run. Because 3 is odd, like the default 13, the half-bit split rounds down, just as it does in the default build. Received data comes either from a loopback of `sout` or from a bench-driven pattern. The expected register contents, transmit sequences and edge spacings are all computed arithmetically.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int REG_W   = 8;
  localparam int LEN_W   = 4;
  localparam int CODE_W  = 3;
  localparam int MAX_SH  = 8;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_PIN  = 2'd3;

  // rate code to left-shift amount: codes 0..6 are 2^code, code 7 is 2^8
  function automatic logic [3:0] code_shift(input logic [CODE_W-1:0] c);
    return (c == 3'd7) ? 4'd8 : {1'b0, c};
  endfunction
endpackage

// File: rtl/spi_fm_clkgen.sv
module spi_fm_clkgen
  import spi_fm_pkg::*;
#(
  parameter int PRESCALE = 13,
  localparam int CNT_W = $clog2(PRESCALE * (1 << MAX_SH) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              mid_stb,
  output logic              end_stb,
  output logic              first_half
);
  localparam logic [CNT_W-1:0] PRE = CNT_W'(PRESCALE);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    period = PRE << code_shift(code);
    half   = period >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)                 cnt <= '0;
    else if (cnt == period - 1'b1)   cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assign mid_stb    = run && (cnt == half);
  assign end_stb    = run && (cnt == period - 1'b1);
  assign first_half = (cnt < half);

  AST_MID_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
    end_stb |-> !mid_stb); // R2
  AST_CNT_IN_BIT: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < period)); // R2
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              start,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              mid_stb,
  input  logic              end_stb,
  input  logic              sin,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] sreg,
  output logic              done
);
  logic             samp;
  logic [LEN_W-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      samp   <= 1'b0;
      bitcnt <= '0;
    end else begin
      if (load) sreg <= load_data;
      if (start) bitcnt <= '0;
      if (mid_stb) samp <= sin;
      if (end_stb) begin
        sreg   <= {sreg[DATA_W-2:0], samp};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assign done = end_stb && (bitcnt == len - 1'b1);

  AST_BITS_WITHIN_FRAME: assert property (@(posedge clk) disable iff (rst)
    run |-> (bitcnt < len)); // R3
  AST_SREG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(end_stb) && !$past(load)) |-> $stable(sreg)); // R5
endmodule

// File: rtl/spi_fm_master.sv
module spi_fm_master
  import spi_fm_pkg::*;
#(
  parameter int PRESCALE = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             sin,
  output logic             sclk,
  output logic             sout,
  output logic             sout_oe,
  output logic             irq
);
  logic              run, flag_en, irq_mask, flag;
  logic [LEN_W-1:0]  len;
  logic [CODE_W-1:0] code;
  logic              mid_stb, end_stb, first_half, done;
  logic [REG_W-1:0]  sreg;
  logic              start, load;

  assign load  = wr_en && (wr_addr == A_DATA) && !run;
  assign start = wr_en && (wr_addr == A_MODE) && !run && wr_data[0] && (len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      flag_en  <= 1'b0;
      irq_mask <= 1'b0;
      flag     <= 1'b0;
      len      <= '0;
      code     <= '0;
      sout_oe  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_DIV && !run) begin
        flag <= flag & wr_data[7];
        len  <= wr_data[6:3];
        code <= wr_data[2:0];
      end
      if (wr_en && wr_addr == A_MODE) begin
        flag_en  <= wr_data[1];
        irq_mask <= wr_data[2];
      end
      if (wr_en && wr_addr == A_PIN) sout_oe <= wr_data[0];
      if (start) run <= 1'b1;
      if (done) begin
        run <= 1'b0;
        if (flag_en) flag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= cpol;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      sclk <= cpol ^ (run && (cpha ? first_half : !first_half));
      irq  <= flag & irq_mask;
      case (rd_addr)
        A_DATA:  rd_data <= sreg;
        A_DIV:   rd_data <= {flag, len, code};
        A_MODE:  rd_data <= {5'b0, irq_mask, flag_en, run};
        default: rd_data <= '0;
      endcase
    end
  end

  assign sout = sreg[REG_W-1];

  spi_fm_clkgen #(.PRESCALE(PRESCALE)) i_clkgen (
    .clk(clk), .rst(rst), .run(run), .code(code),
    .mid_stb(mid_stb), .end_stb(end_stb), .first_half(first_half)
  );

  spi_fm_shifter #(.DATA_W(REG_W)) i_shifter (
    .clk(clk), .rst(rst), .run(run), .start(start), .load(load),
    .load_data(wr_data), .mid_stb(mid_stb), .end_stb(end_stb),
    .sin(sin), .len(len), .sreg(sreg), .done(done)
  );

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run) |-> ($stable(len) && $stable(code))); // R7
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(done)); // R8
  AST_RUN_HW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(done)); // R6
endmodule

// File: tb/test_spi_fm_master.sv
module test_spi_fm_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'd0, rd_data;
  logic cpol = 1'b0, cpha = 1'b0;
  logic sclk, sout, sout_oe, irq, sin;
  logic lb = 1'b1, pat_sin = 1'b0;
  logic [15:0] pat = 16'd0;

  int nchk = 0, nerr = 0, cyc = 0, tog = 0, bitk = 0;
  int ts [1:4];
  logic txb [0:15];
  logic sclk_q = 1'b0;

  always #10 clk = ~clk;
  assign sin = lb ? sout : pat_sin;

  spi_fm_master #(.PRESCALE(3)) i_spi_fm_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cpol(cpol), .cpha(cpha), .sin(sin),
    .sclk(sclk), .sout(sout), .sout_oe(sout_oe), .irq(irq)
  );

  always @(negedge clk) begin
    cyc++;
    if (sclk !== sclk_q) begin
      tog++;
      if (tog <= 4) ts[tog] = cyc;
      if ((cpha == 1'b0 && tog % 2 == 1) || (cpha == 1'b1 && tog % 2 == 0)) begin
        if (bitk < 16) txb[bitk] = sout;
        bitk++;
        if (bitk < 16) pat_sin = pat[bitk];
      end
    end
    sclk_q = sclk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #5;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #5;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #5;
    rd_addr = a;
    @(posedge clk); #5;
    v = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    int n = 0;
    do begin rd(2'd2, v); n++; end while (v[0] && n < 3000);
  endtask

  task automatic frame(input logic [7:0] d, input int len, input int code, input logic [1:0] mi);
    wr(2'd0, d);
    wr(2'd1, {1'b1, len[3:0], code[2:0]});
    @(posedge clk); #5;
    tog = 0; bitk = 0; pat_sin = pat[0];
    wr(2'd2, {5'b0, mi, 1'b1});
    wait_idle();
  endtask

  function automatic logic [7:0] exp_rx(input logic [7:0] d, input int len, input logic [15:0] p);
    for (int k = 0; k < len; k++) d = {d[6:0], p[k]};
    return d;
  endfunction

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog expired (all R)");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v, d, e;
    int p;
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;
    // R1 reset state
    rd(2'd1, v); chk("R1 divider reset", v, 8'h00);
    rd(2'd2, v); chk("R1 mode reset", v, 8'h00);
    chk("R1 irq reset", irq, 0);
    chk("R1 sout_oe reset", sout_oe, 0);
    chk("R1 sclk idle", sclk, cpol);

    // R4 loopback sweep over every mode and length
    lb = 1'b1;
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      for (int len = 1; len <= 15; len++) begin
        for (int j = 0; j < 2; j++) begin
          d = 8'(len * 37 + m * 11 + j * 90 + 1);
          frame(d, len, 0, 2'b00);
          rd(2'd0, v);
          e = d;
          for (int k = 0; k < len; k++) e = {e[6:0], e[7]};
          chk($sformatf("R4 loopback m=%0d len=%0d", m, len), v, e);
          chk($sformatf("R3 bit count m=%0d len=%0d", m, len), bitk, len);
          chk($sformatf("R10 clock edges m=%0d len=%0d", m, len), tog, 2 * len);
        end
      end
    end

    // R5 driven pattern: receive and transmit order
    lb = 1'b0;
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      for (int li = 0; li < 5; li++) begin
        int len;
        logic ok;
        len = (li == 0) ? 1 : (li == 1) ? 5 : (li == 2) ? 8 : (li == 3) ? 9 : 15;
        pat = 16'(16'h5A3C ^ (m * 16'h1111) ^ (len * 16'h0203));
        d = 8'(8'hC6 ^ len);
        frame(d, len, 1, 2'b00);
        rd(2'd0, v);
        chk($sformatf("R5 received m=%0d len=%0d", m, len), v, exp_rx(d, len, pat));
        e = d; ok = 1'b1;
        for (int k = 0; k < len; k++) begin
          if (txb[k] !== e[7]) ok = 1'b0;
          e = {e[6:0], pat[k]};
        end
        chk($sformatf("R4 transmit order m=%0d len=%0d", m, len), ok, 1);
      end
    end
    lb = 1'b1;

    // R2 bit period and active half for each rate code
    cpol = 1'b0; cpha = 1'b1;
    for (int c = 0; c < 8; c++) begin
      p = 3 << ((c == 7) ? 8 : c);
      frame(8'hA5, 2, c, 2'b00);
      chk($sformatf("R2 period code=%0d", c), ts[3] - ts[1], p);
      chk($sformatf("R2 active half cpha1 code=%0d", c), ts[2] - ts[1], p / 2);
    end
    cpha = 1'b0;
    frame(8'hA5, 2, 1, 2'b00);
    chk("R2 active half cpha0 code=1", ts[2] - ts[1], 6 - 3);

    // R3 zero length does not start
    wr(2'd1, 8'h80);
    @(posedge clk); #5; tog = 0;
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R3 zero length run", v[0], 0);
    repeat (20) @(posedge clk);
    #5 chk("R3 zero length edges", tog, 0);

    // R6 R7 writes during a frame
    cpha = 1'b1;
    wr(2'd0, 8'h3B);
    wr(2'd1, {1'b1, 4'd15, 3'd2});
    @(posedge clk); #5; tog = 0; bitk = 0;
    wr(2'd2, 8'h01);
    repeat (10) @(posedge clk);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R6 run kept after write 0", v[0], 1);
    wait_idle();
    rd(2'd0, v);
    e = 8'h3B;
    for (int k = 0; k < 15; k++) e = {e[6:0], e[7]};
    chk("R7 data write ignored", v, e);
    rd(2'd1, v); chk("R7 divider write ignored", v, {1'b0, 4'd15, 3'd2});

    // R8 flag and interrupt
    frame(8'h11, 3, 0, 2'b11);
    rd(2'd1, v); chk("R8 flag set", v[7], 1);
    chk("R8 irq masked on", irq, 1);
    wr(2'd1, {1'b1, 4'd3, 3'd0});
    rd(2'd1, v); chk("R8 write 1 keeps flag", v[7], 1);
    wr(2'd1, {1'b0, 4'd3, 3'd0});
    rd(2'd1, v); chk("R8 write 0 clears", v[7], 0);
    chk("R8 irq drops", irq, 0);
    wr(2'd1, {1'b1, 4'd3, 3'd0});
    rd(2'd1, v); chk("R8 write 1 cannot set", v[7], 0);
    frame(8'h11, 3, 0, 2'b01);
    rd(2'd1, v); chk("R8 flag set mask off", v[7], 1);
    chk("R8 irq mask off", irq, 0);
    wr(2'd1, {1'b0, 4'd3, 3'd0});
    frame(8'h11, 3, 0, 2'b00);
    rd(2'd1, v); chk("R8 flag disabled", v[7], 0);

    // R9 pin enable
    wr(2'd3, 8'h01);
    chk("R9 oe on", sout_oe, 1);
    rd(2'd3, v); chk("R9 pin reg reads zero", v, 8'h00);
    wr(2'd3, 8'h00);
    chk("R9 oe off", sout_oe, 0);

    // R10 idle level with polarity 1
    cpol = 1'b1;
    repeat (3) @(posedge clk);
    #5 chk("R10 idle high", sclk, 1);
    frame(8'h77, 4, 0, 2'b00);
    repeat (2) @(posedge clk);
    #5 chk("R10 idle high after frame", sclk, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule